// File: doc/BRIEF.md
# SCSI Host Adapter Interrupt and Status Unit

This unit keeps the status byte, the interrupt-cause byte and the sequence-step value of a byte-wide SCSI host adapter, and drives the adapter's single interrupt line. A host reaches it through an 8-entry register window with read and write strobes. The command path passes it decoded command operation codes. The transfer and selection logic reports events to it as one-cycle pulses. The unit does not sequence bus phases or move data.

The interrupt line always equals one status bit. Any interrupt source sets that bit. A read of the cause register clears it, and the same read also zeroes the cause, clears the transfer-count-zero flag and moves the step to the command-done code. If a new event arrives in the same cycle as that read, the event takes precedence, so no interrupt is lost. A configuration bit can stop a bus-reset report from raising the interrupt. A chip reset command resets the whole unit, as does the synchronous reset input.

Register map (3-bit address): 0 count low, 1 count middle, 2 status, 3 cause, 4 step, 5 FIFO flags, 6 config 1, 7 count high / chip identifier. Status bits: 7 interrupt, 4 count zero. Cause bits: 7 bus reset, 5 disconnect, 4 bus service, 3 function complete. Config 1 bit 6 is the reset-report disable. Operation codes (7 bits): 0x01 flush, 0x02 chip reset, 0x03 bus reset, 0x12 message accepted, 0x44 enable selection, 0x45 disable selection. The chip identifier defaults to 0xA2. Bit positions are parameters, and the values above are their defaults.

Top module: `scsi_irq_status`

## Requirements
- R1: After reset, status, cause, step, flags, count low and count middle read 0, config 1 reads 0x07, address 7 reads 0xA2, and irq_o is low.
- R2: A read of address 3 returns the cause value from before the read. Afterwards the cause reads 0, the step reads 4, status bit 4 is clear and irq_o is low.
- R3: A write to address 0 or address 1 clears status bit 4.
- R4: Operation 0x03 sets the cause to 0x80. It raises irq_o only when config 1 bit 6 is clear.
- R5: Operation 0x01 sets the cause to 0x08, zeroes the step and the flags, and leaves irq_o unchanged.
- R6: Operation 0x12 sets the cause to 0x20, zeroes the step and the flags, and raises irq_o.
- R7: Operation 0x45 zeroes the cause and raises irq_o. Operation 0x44 zeroes the cause and leaves irq_o unchanged.
- R8: A no-device selection pulse clears the status (apart from the interrupt bit it then sets), sets the cause to 0x20, zeroes the step and raises irq_o.
- R9: Operation 0x02 returns every register to its R1 value and lowers irq_o.
- R10: irq_o always equals status bit 7. A function-complete pulse sets cause bit 3 and a bus-service pulse sets cause bit 4, and each raises irq_o. A count-zero pulse sets status bit 4 without raising irq_o.
- R11: An event pulse in the same cycle as a cause read leaves irq_o high, and the event's cause bit remains set.
- R12: A flags-load pulse stores the 5-bit FIFO count, which reads back at address 5. Read data appears on reg_rdata in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| cmd_stb | input | 1 | Command strobe |
| cmd_op | input | 7 | Command operation code |
| ev_fc | input | 1 | Function-complete event pulse |
| ev_bs | input | 1 | Bus-service event pulse |
| ev_tc | input | 1 | Transfer-count-zero event pulse |
| ev_nodev | input | 1 | Selection found no device |
| fifo_cnt_ld | input | 1 | Load FIFO flags |
| fifo_cnt | input | 5 | FIFO byte count |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume three things about the inputs: read and write strobes never target the same address in the same cycle, a chip reset operation is never combined with a register read, and the no-device pulse does not coincide with other event pulses. The stimulus drives one action per cycle, except for the deliberate pairing of an event with a cause read. It keeps resets apart from reads, and before every chip reset it reaches non-reset values by register writes, so the reset has a visible effect.

// File: rtl/scsi_isu_pkg.sv
package scsi_isu_pkg;
  typedef enum logic [2:0] {
    RA_CNT_LO  = 3'd0,
    RA_CNT_MID = 3'd1,
    RA_STATUS  = 3'd2,
    RA_CAUSE   = 3'd3,
    RA_STEP    = 3'd4,
    RA_FLAGS   = 3'd5,
    RA_CFG1    = 3'd6,
    RA_CNT_HI  = 3'd7
  } reg_addr_e;

  typedef enum logic [6:0] {
    OP_NOP     = 7'h00,
    OP_FLUSH   = 7'h01,
    OP_CHIPRST = 7'h02,
    OP_BUSRST  = 7'h03,
    OP_MSGOK   = 7'h12,
    OP_SELON   = 7'h44,
    OP_SELOFF  = 7'h45
  } cmd_op_e;

  typedef struct packed {
    logic rd_cause;
    logic wr_lo;
    logic wr_mid;
    logic wr_cfg1;
    logic flush;
    logic chiprst;
    logic busrst;
    logic msgok;
    logic selon;
    logic seloff;
  } isu_ctl_t;
endpackage

// File: rtl/scsi_isu_cause.sv
module scsi_isu_cause #(
  parameter int DATA_W    = 8,
  parameter int STEP_W    = 3,
  parameter int RST_BIT   = 7,
  parameter int DC_BIT    = 5,
  parameter int BS_BIT    = 4,
  parameter int FC_BIT    = 3,
  parameter int STEP_DONE = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              rd_cause,
  input  logic              flush,
  input  logic              msgok,
  input  logic              busrst,
  input  logic              sel_chg,
  input  logic              ev_fc,
  input  logic              ev_bs,
  input  logic              ev_nodev,
  output logic [DATA_W-1:0] cause_q,
  output logic [STEP_W-1:0] step_q
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] cause_n;
  logic [STEP_W-1:0] step_n;

  always_comb begin
    cause_n = cause_q;
    step_n  = step_q;
    if (rd_cause) begin
      cause_n = '0;
      step_n  = STEP_W'(STEP_DONE);
    end
    if (flush) begin
      cause_n = ONE << FC_BIT;
      step_n  = '0;
    end
    if (msgok) begin
      cause_n = ONE << DC_BIT;
      step_n  = '0;
    end
    if (busrst)  cause_n = ONE << RST_BIT;
    if (sel_chg) cause_n = '0;
    // events come last so that they override a same-cycle clear
    if (ev_nodev) begin
      cause_n = ONE << DC_BIT;
      step_n  = '0;
    end
    if (ev_fc) cause_n[FC_BIT] = 1'b1;
    if (ev_bs) cause_n[BS_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      cause_q <= '0;
      step_q  <= '0;
    end else begin
      cause_q <= cause_n;
      step_q  <= step_n;
    end
  end
endmodule

// File: rtl/scsi_isu_status.sv
module scsi_isu_status #(
  parameter int DATA_W  = 8,
  parameter int IRQ_BIT = 7,
  parameter int TC_BIT  = 4
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              rd_cause,
  input  logic              wr_cnt,
  input  logic              ev_tc,
  input  logic              ev_nodev,
  input  logic              raise,
  output logic [DATA_W-1:0] status_q
);
  logic [DATA_W-1:0] status_n;

  always_comb begin
    status_n = status_q;
    if (rd_cause) begin
      status_n[TC_BIT]  = 1'b0;
      status_n[IRQ_BIT] = 1'b0;
    end
    if (wr_cnt)   status_n[TC_BIT]  = 1'b0;
    if (ev_nodev) status_n          = '0;
    if (ev_tc)    status_n[TC_BIT]  = 1'b1;
    if (raise)    status_n[IRQ_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr) status_q <= '0;
    else     status_q <= status_n;
  end
endmodule

// File: rtl/scsi_isu_regs.sv
module scsi_isu_regs #(
  parameter int              DATA_W    = 8,
  parameter int              FLAGS_W   = 5,
  parameter logic [DATA_W-1:0] CFG1_INIT = 8'h07,
  parameter logic [DATA_W-1:0] CHIP_ID   = 8'hA2
) (
  input  logic               clk,
  input  logic               clr,
  input  logic               wr_lo,
  input  logic               wr_mid,
  input  logic               wr_cfg1,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               flags_zero,
  input  logic               fifo_cnt_ld,
  input  logic [FLAGS_W-1:0] fifo_cnt,
  output logic [DATA_W-1:0]  cnt_lo_q,
  output logic [DATA_W-1:0]  cnt_mid_q,
  output logic [DATA_W-1:0]  cnt_hi_q,
  output logic [DATA_W-1:0]  cfg1_q,
  output logic [FLAGS_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_lo_q  <= '0;
      cnt_mid_q <= '0;
      cnt_hi_q  <= CHIP_ID;
      cfg1_q    <= CFG1_INIT;
      flags_q   <= '0;
    end else begin
      if (wr_lo)   cnt_lo_q  <= wdata;
      if (wr_mid)  cnt_mid_q <= wdata;
      if (wr_cfg1) cfg1_q    <= wdata;
      if (flags_zero)       flags_q <= '0;
      else if (fifo_cnt_ld) flags_q <= fifo_cnt;
    end
  end
endmodule

// File: rtl/scsi_irq_status.sv
module scsi_irq_status
  import scsi_isu_pkg::*;
#(
  parameter int              ADDR_W        = 3,
  parameter int              DATA_W        = 8,
  parameter int              STEP_W        = 3,
  parameter int              FLAGS_W       = 5,
  parameter int              STAT_IRQ_BIT  = 7,
  parameter int              STAT_TC_BIT   = 4,
  parameter int              CAUSE_RST_BIT = 7,
  parameter int              CAUSE_DC_BIT  = 5,
  parameter int              CAUSE_BS_BIT  = 4,
  parameter int              CAUSE_FC_BIT  = 3,
  parameter int              CFG_RRDIS_BIT = 6,
  parameter int              STEP_DONE     = 4,
  parameter logic [DATA_W-1:0] CFG1_INIT   = 8'h07,
  parameter logic [DATA_W-1:0] CHIP_ID     = 8'hA2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_rd,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic               cmd_stb,
  input  logic [6:0]         cmd_op,
  input  logic               ev_fc,
  input  logic               ev_bs,
  input  logic               ev_tc,
  input  logic               ev_nodev,
  input  logic               fifo_cnt_ld,
  input  logic [FLAGS_W-1:0] fifo_cnt,
  output logic               irq_o
);
  isu_ctl_t          ctl;
  logic              clr;
  logic              raise;
  logic [DATA_W-1:0] cause_q, status_q, cfg1_q;
  logic [DATA_W-1:0] cnt_lo_q, cnt_mid_q, cnt_hi_q;
  logic [STEP_W-1:0] step_q;
  logic [FLAGS_W-1:0] flags_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    ctl          = '0;
    ctl.rd_cause = reg_rd && (reg_addr == ADDR_W'(RA_CAUSE));
    ctl.wr_lo    = reg_wr && (reg_addr == ADDR_W'(RA_CNT_LO));
    ctl.wr_mid   = reg_wr && (reg_addr == ADDR_W'(RA_CNT_MID));
    ctl.wr_cfg1  = reg_wr && (reg_addr == ADDR_W'(RA_CFG1));
    if (cmd_stb) begin
      unique case (cmd_op)
        OP_FLUSH:   ctl.flush   = 1'b1;
        OP_CHIPRST: ctl.chiprst = 1'b1;
        OP_BUSRST:  ctl.busrst  = 1'b1;
        OP_MSGOK:   ctl.msgok   = 1'b1;
        OP_SELON:   ctl.selon   = 1'b1;
        OP_SELOFF:  ctl.seloff  = 1'b1;
        default:    ;
      endcase
    end
  end

  assign clr   = rst | ctl.chiprst;
  assign raise = (ctl.busrst && !cfg1_q[CFG_RRDIS_BIT]) | ctl.msgok | ctl.seloff
               | ev_fc | ev_bs | ev_nodev;

  scsi_isu_cause #(
    .DATA_W(DATA_W), .STEP_W(STEP_W), .RST_BIT(CAUSE_RST_BIT), .DC_BIT(CAUSE_DC_BIT),
    .BS_BIT(CAUSE_BS_BIT), .FC_BIT(CAUSE_FC_BIT), .STEP_DONE(STEP_DONE)
  ) u_cause (
    .clk(clk), .clr(clr), .rd_cause(ctl.rd_cause), .flush(ctl.flush), .msgok(ctl.msgok),
    .busrst(ctl.busrst), .sel_chg(ctl.selon | ctl.seloff), .ev_fc(ev_fc), .ev_bs(ev_bs),
    .ev_nodev(ev_nodev), .cause_q(cause_q), .step_q(step_q)
  );

  scsi_isu_status #(
    .DATA_W(DATA_W), .IRQ_BIT(STAT_IRQ_BIT), .TC_BIT(STAT_TC_BIT)
  ) u_status (
    .clk(clk), .clr(clr), .rd_cause(ctl.rd_cause), .wr_cnt(ctl.wr_lo | ctl.wr_mid),
    .ev_tc(ev_tc), .ev_nodev(ev_nodev), .raise(raise), .status_q(status_q)
  );

  scsi_isu_regs #(
    .DATA_W(DATA_W), .FLAGS_W(FLAGS_W), .CFG1_INIT(CFG1_INIT), .CHIP_ID(CHIP_ID)
  ) u_regs (
    .clk(clk), .clr(clr), .wr_lo(ctl.wr_lo), .wr_mid(ctl.wr_mid), .wr_cfg1(ctl.wr_cfg1),
    .wdata(reg_wdata), .flags_zero(ctl.flush | ctl.msgok), .fifo_cnt_ld(fifo_cnt_ld),
    .fifo_cnt(fifo_cnt), .cnt_lo_q(cnt_lo_q), .cnt_mid_q(cnt_mid_q), .cnt_hi_q(cnt_hi_q),
    .cfg1_q(cfg1_q), .flags_q(flags_q)
  );

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(RA_CNT_LO):  rd_mux = cnt_lo_q;
      ADDR_W'(RA_CNT_MID): rd_mux = cnt_mid_q;
      ADDR_W'(RA_STATUS):  rd_mux = status_q;
      ADDR_W'(RA_CAUSE):   rd_mux = cause_q;
      ADDR_W'(RA_STEP):    rd_mux = DATA_W'(step_q);
      ADDR_W'(RA_FLAGS):   rd_mux = DATA_W'(flags_q);
      ADDR_W'(RA_CFG1):    rd_mux = cfg1_q;
      default:             rd_mux = cnt_hi_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign irq_o = status_q[STAT_IRQ_BIT];
endmodule

// File: rtl/scsi_isu_checker.sv
module scsi_isu_checker
  import scsi_isu_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int DATA_W    = 8,
  parameter int TC_BIT    = 4,
  parameter int RRDIS_BIT = 6,
  parameter logic [DATA_W-1:0] CFG1_INIT = 8'h07
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              cmd_stb,
  input logic [6:0]        cmd_op,
  input logic              ev_fc,
  input logic              ev_bs,
  input logic              ev_tc,
  input logic              ev_nodev,
  input logic              irq_o,
  input logic [DATA_W-1:0] cause_q,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] cfg1_q
);
  logic any_ev, rd_cause, chiprst;
  assign any_ev   = ev_fc | ev_bs | ev_nodev;
  assign rd_cause = reg_rd && (reg_addr == ADDR_W'(RA_CAUSE));
  assign chiprst  = cmd_stb && (cmd_op == OP_CHIPRST);

  p_rdclr_r2: assert property (@(posedge clk) disable iff (rst)
    rd_cause && !any_ev && !cmd_stb |=> !irq_o && (cause_q == '0));

  p_cntwr_r3: assert property (@(posedge clk) disable iff (rst)
    reg_wr && (reg_addr == ADDR_W'(RA_CNT_LO) || reg_addr == ADDR_W'(RA_CNT_MID))
      && !ev_tc && !chiprst |=> !status_q[TC_BIT]);

  p_rrmask_r4: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && (cmd_op == OP_BUSRST) && cfg1_q[RRDIS_BIT] && !irq_o && !any_ev |=> !irq_o);

  p_selon_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_stb && (cmd_op == OP_SELON) && !any_ev && !rd_cause |=> (cause_q == '0) && $stable(irq_o));

  p_chiprst_r9: assert property (@(posedge clk) disable iff (rst)
    chiprst |=> (cfg1_q == CFG1_INIT) && !irq_o && (cause_q == '0));

  p_raise_r11: assert property (@(posedge clk) disable iff (rst)
    any_ev && !chiprst |=> irq_o);
endmodule

bind scsi_irq_status scsi_isu_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TC_BIT(STAT_TC_BIT),
  .RRDIS_BIT(CFG_RRDIS_BIT), .CFG1_INIT(CFG1_INIT)
) u_isu_chk (
  .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_stb(cmd_stb), .cmd_op(cmd_op), .ev_fc(ev_fc), .ev_bs(ev_bs), .ev_tc(ev_tc),
  .ev_nodev(ev_nodev), .irq_o(irq_o), .cause_q(cause_q), .status_q(status_q), .cfg1_q(cfg1_q)
);

// File: tb/scsi_irq_status_bench.sv
`timescale 1ns/1ps
module scsi_irq_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_rd = 0, reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       cmd_stb = 0;
  logic [6:0] cmd_op = 0;
  logic       ev_fc = 0, ev_bs = 0, ev_tc = 0, ev_nodev = 0, fifo_cnt_ld = 0;
  logic [4:0] fifo_cnt = 0;
  logic       irq_o;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  scsi_irq_status u_scsi_irq_status (
    .clk(clk), .rst(rst), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_stb(cmd_stb), .cmd_op(cmd_op),
    .ev_fc(ev_fc), .ev_bs(ev_bs), .ev_tc(ev_tc), .ev_nodev(ev_nodev),
    .fifo_cnt_ld(fifo_cnt_ld), .fifo_cnt(fifo_cnt), .irq_o(irq_o)
  );

  // behavioural reference model
  int m_status, m_cause, m_step, m_flags, m_cfg1, m_lo, m_mid, m_rdata;

  task automatic model_reset();
    m_status = 0; m_cause = 0; m_step = 0; m_flags = 0;
    m_cfg1 = 7; m_lo = 0; m_mid = 0;
  endtask

  function automatic int model_read(int a);
    case (a)
      0: return m_lo;      1: return m_mid;
      2: return m_status;  3: return m_cause;
      4: return m_step;    5: return m_flags;
      6: return m_cfg1;    default: return 'hA2;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_rdata = 0;
      model_reset();
    end else begin
      if (reg_rd) m_rdata = model_read(int'(reg_addr));
      if (cmd_stb && cmd_op == 7'h02) model_reset();
      else begin
        int ns, nc, nst, nf;
        bit irq, raise;
        ns = m_status; nc = m_cause; nst = m_step; nf = m_flags;
        irq = ns[7]; raise = 0;
        if (reg_rd && reg_addr == 3) begin nc = 0; ns[4] = 0; irq = 0; nst = 4; end
        if (reg_wr) begin
          if (reg_addr == 0) begin m_lo = reg_wdata; ns[4] = 0; end
          if (reg_addr == 1) begin m_mid = reg_wdata; ns[4] = 0; end
          if (reg_addr == 6) m_cfg1 = reg_wdata;
        end
        if (fifo_cnt_ld) nf = fifo_cnt;
        if (cmd_stb) begin
          case (cmd_op)
            7'h01: begin nc = 'h08; nst = 0; nf = 0; end
            7'h03: begin nc = 'h80; if (!m_cfg1[6]) raise = 1; end
            7'h12: begin nc = 'h20; nst = 0; nf = 0; raise = 1; end
            7'h44: nc = 0;
            7'h45: begin nc = 0; raise = 1; end
            default: ;
          endcase
        end
        if (ev_nodev) begin ns = 0; irq = 0; nc = 'h20; nst = 0; raise = 1; end
        if (ev_fc) begin nc = nc | 'h08; raise = 1; end
        if (ev_bs) begin nc = nc | 'h10; raise = 1; end
        if (ev_tc) ns[4] = 1;
        ns[7] = irq | raise;
        m_status = ns; m_cause = nc; m_step = nst; m_flags = nf;
      end
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cur_req, int'(irq_o), int'(m_status[7]), "irq vs model (R10)");
      check(cur_req, int'(reg_rdata), m_rdata, "rdata vs model");
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #0.5;
    reg_rd = 0; reg_wr = 0; cmd_stb = 0; ev_fc = 0; ev_bs = 0; ev_tc = 0;
    ev_nodev = 0; fifo_cnt_ld = 0;
  endtask

  task automatic rd(int a, int exp, string req);
    reg_rd = 1; reg_addr = 3'(a);
    tick();
    check(req, int'(reg_rdata), exp, $sformatf("read addr %0d", a));
  endtask

  task automatic wr(int a, int v);
    reg_wr = 1; reg_addr = 3'(a); reg_wdata = 8'(v);
    tick();
  endtask

  task automatic cmd(int op);
    cmd_stb = 1; cmd_op = 7'(op);
    tick();
  endtask

  task automatic irq_is(int exp, string req);
    check(req, int'(irq_o), exp, "irq_o");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=<5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 0;
    @(negedge clk); #0.5;
    // R1 reset state
    cur_req = "R1";
    irq_is(0, "R1");
    rd(0, 0, "R1"); rd(1, 0, "R1"); rd(2, 0, "R1"); rd(3, 0, "R1");
    rd(4, 4, "R1 step after cause read");
    rd(5, 0, "R1"); rd(6, 7, "R1"); rd(7, 'hA2, "R1");
    // R10 / R2
    cur_req = "R10";
    ev_fc = 1; tick(); irq_is(1, "R10 fc raise");
    rd(2, 'h80, "R10 status mirrors irq");
    cur_req = "R2";
    rd(3, 'h08, "R2 cause returned before clear");
    irq_is(0, "R2");
    rd(3, 0, "R2 cause zeroed"); rd(4, 4, "R2 step done"); rd(2, 0, "R2 status");
    // R3
    cur_req = "R3";
    ev_tc = 1; tick(); irq_is(0, "R10 tc no irq"); rd(2, 'h10, "R10 tc status");
    wr(0, 'h5A); rd(2, 0, "R3 lo write clears tc"); rd(0, 'h5A, "R3 lo stored");
    ev_tc = 1; tick(); wr(1, 'hC3); rd(2, 0, "R3 mid write clears tc");
    // R4
    cur_req = "R4";
    wr(6, 'h47); cmd('h03); irq_is(0, "R4 masked"); rd(3, 'h80, "R4 cause");
    wr(6, 'h07); cmd('h03); irq_is(1, "R4 unmasked"); rd(3, 'h80, "R4 cause");
    irq_is(0, "R2");
    // R12 / R5
    cur_req = "R12";
    fifo_cnt_ld = 1; fifo_cnt = 5'h13; tick(); rd(5, 'h13, "R12 flags load");
    cur_req = "R5";
    ev_bs = 1; tick(); irq_is(1, "R10 bs raise");
    cmd('h01); irq_is(1, "R5 irq unchanged");
    rd(5, 0, "R5 flags"); rd(4, 0, "R5 step"); rd(3, 'h08, "R5 cause");
    cmd('h01); irq_is(0, "R5 irq stays low");
    // R6
    cur_req = "R6";
    fifo_cnt_ld = 1; fifo_cnt = 5'h07; tick(); rd(3, 'h08, "R6 prep");
    cmd('h12); irq_is(1, "R6 raise");
    rd(5, 0, "R6 flags"); rd(4, 0, "R6 step"); rd(3, 'h20, "R6 cause");
    // R7
    cur_req = "R7";
    ev_bs = 1; tick(); cmd('h44); irq_is(1, "R7 selon keeps irq");
    rd(3, 0, "R7 selon cause zero"); irq_is(0, "R7");
    cmd('h45); irq_is(1, "R7 seloff raises"); rd(3, 0, "R7 seloff cause zero");
    // R8
    cur_req = "R8";
    ev_tc = 1; tick();
    ev_nodev = 1; tick(); irq_is(1, "R8 raise");
    rd(2, 'h80, "R8 status cleared"); rd(4, 0, "R8 step zero"); rd(3, 'h20, "R8 cause");
    // R11 same-cycle raise and read clear
    cur_req = "R11";
    ev_fc = 1; tick();
    reg_rd = 1; reg_addr = 3; ev_bs = 1; tick();
    check("R11", int'(reg_rdata), 'h08, "old cause");
    irq_is(1, "R11 raise wins");
    rd(3, 'h10, "R11 event cause kept");
    // R9 soft reset
    cur_req = "R9";
    wr(6, 'h55); wr(0, 'h33); ev_bs = 1; tick(); irq_is(1, "R9 prep");
    cmd('h02); irq_is(0, "R9 irq low");
    rd(6, 7, "R9 cfg1"); rd(0, 0, "R9 lo"); rd(2, 0, "R9 status"); rd(7, 'hA2, "R9 chip id");
    // R1 hardware reset mid-run
    cur_req = "R1";
    wr(1, 'h99); ev_fc = 1; tick();
    rst = 1; tick(); rst = 0; tick();
    irq_is(0, "R1 rst"); rd(1, 0, "R1 mid after rst");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule